// File: doc/BRIEF.md
# Display Transmitter Control-Register Slave

This block stands in for the control registers of a video transmitter that a host reaches over an I2C-style byte bus. It does not decode SCL or SDA. A separate bus engine hands it byte-level events, each one a single-cycle pulse: write start, read start, a written byte, a read strobe and a finish. The block keeps an 8-bit register pointer that advances on every access. It answers with canned values: an identity code and a status code that reports a sink as present.

One register, system control, carries a two-bit request/grant handshake. A host first writes the request bit together with the grant bit, which moves the block into passthrough mode so the host can reach the display-data-channel memory behind it. A later write with the request bit clear returns the block to normal mode. On entry to passthrough mode the block also raises a one-shot flag. The bus engine uses that flag to ignore the next finish event, and the flag clears on that event. Writes to every other register are accepted but do nothing.

Top module: `disp_xmtr_regs`

## Requirements
- R1: After reset the pointer is 0x00, `passthru` and `skip_finish` are low, and `rd_data` is 0x00.
- R2: The first byte written after `wr_start` loads the pointer and is not register data. A `rd_start` also ends this pointer phase.
- R3: Each register write and each read strobe advances the pointer by one, and the pointer wraps from 0xFF to 0x00.
- R4: A write to 0x1A with bit 2 (request, 0x04) set sets the request state. If bit 1 (grant, 0x02) is also set, `passthru` and `skip_finish` go high on the next cycle.
- R5: A write to 0x1A with bit 2 clear clears both the request state and `passthru`.
- R6: A read of 0x1A returns 0x06 while the request state is set, and 0x00 otherwise.
- R7: A read of 0x1B returns 0xB0.
- R8: A read of 0x3D returns 0x04.
- R9: A read of any other address returns 0x00. A write to any other address changes nothing but the pointer.
- R10: `skip_finish` clears on the cycle after a `finish` pulse. It rises only together with entry into passthrough mode, and only while `passthru` is high.
- R11: `rd_data` takes its new value on the cycle after `rd_strobe` and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Start-of-write event pulse |
| rd_start | input | 1 | Start-of-read event pulse |
| wr_byte_vld | input | 1 | Written byte present on `wr_byte` |
| wr_byte | input | 8 | Written byte |
| rd_strobe | input | 1 | Read request for the byte at the pointer |
| finish | input | 1 | Stop/finish event pulse |
| rd_data | output | 8 | Read byte, valid the cycle after `rd_strobe` |
| passthru | output | 1 | Passthrough (display data channel) mode flag |
| skip_finish | output | 1 | One-shot: engine ignores the next finish |

## Verification
On every cycle the assertions check four things. The pointer steps by one on each access. `rd_data` holds still between strobes. `passthru` and `skip_finish` change only on the events that are allowed to move them. A read never returns a value outside the four legal codes. Only the bench scenarios can show how each address maps to its value, and the bench does this with a full 256-address read sweep from reset. The scenarios are also the only way to show the order of the handshake, meaning request alone versus request with grant, and the drop back to normal mode. They also cover the wrap of the pointer and the rule that the pointer byte is not register data.

// File: rtl/disp_xmtr_regs.sv
module disp_xmtr_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] SYSCTL_ADDR = 8'h1A,
  parameter logic [AW-1:0] ID_ADDR     = 8'h1B,
  parameter logic [AW-1:0] STAT_ADDR   = 8'h3D,
  parameter logic [DW-1:0] ID_VAL      = 8'hB0,
  parameter logic [DW-1:0] STAT_VAL    = 8'h04,
  parameter int REQ_BIT = 2,
  parameter int GNT_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          rd_start,
  input  logic          wr_byte_vld,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_strobe,
  input  logic          finish,
  output logic [DW-1:0] rd_data,
  output logic          passthru,
  output logic          skip_finish
);

  localparam logic [DW-1:0] HS_VAL = DW'((1 << REQ_BIT) | (1 << GNT_BIT));

  logic [AW-1:0] ptr;
  logic          addr_phase;
  logic          req;
  logic [DW-1:0] rd_val;

  wire reg_wr   = wr_byte_vld && !wr_start && !addr_phase;
  wire ptr_ld   = wr_byte_vld && !wr_start && addr_phase;
  wire rd_acc   = rd_strobe && !wr_start && !wr_byte_vld;
  wire ctl_wr   = reg_wr && (ptr == SYSCTL_ADDR);
  wire want_req = wr_byte[REQ_BIT];
  wire want_gnt = wr_byte[GNT_BIT];
  wire enter_pt = ctl_wr && want_req && want_gnt;

  always_comb begin
    rd_val = '0;
    if (ptr == SYSCTL_ADDR)    rd_val = req ? HS_VAL : '0;
    else if (ptr == ID_ADDR)   rd_val = ID_VAL;
    else if (ptr == STAT_ADDR) rd_val = STAT_VAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      addr_phase <= 1'b0;
      req        <= 1'b0;
      passthru   <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (wr_start)
        addr_phase <= 1'b1;
      else if (ptr_ld || rd_start)
        addr_phase <= 1'b0;

      if (ptr_ld)
        ptr <= wr_byte[AW-1:0];
      else if (reg_wr || rd_acc)
        ptr <= ptr + 1'b1;

      if (ctl_wr) begin
        if (want_req) begin
          req <= 1'b1;
          if (want_gnt) passthru <= 1'b1;
        end else begin
          req      <= 1'b0;
          passthru <= 1'b0;
        end
      end

      if (rd_acc)
        rd_data <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      skip_finish <= 1'b0;
    else if (enter_pt)
      skip_finish <= 1'b1;
    else if (finish)
      skip_finish <= 1'b0;
  end

endmodule

// File: rtl/disp_xmtr_regs_chk.sv
module disp_xmtr_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_start,
  input logic       wr_byte_vld,
  input logic       rd_strobe,
  input logic       finish,
  input logic [7:0] ptr,
  input logic [7:0] rd_data,
  input logic       passthru,
  input logic       skip_finish
);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !wr_start && !wr_byte_vld) |=> ptr == $past(ptr) + 8'd1);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));

  // R9
  rd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == 8'h00 || rd_data == 8'h06 || rd_data == 8'hB0 || rd_data == 8'h04);

  // R4
  pt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(passthru) |-> $past(wr_byte_vld));

  // R10
  skip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_finish) |-> passthru);

  // R10
  skip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(skip_finish) |-> $past(finish));

endmodule

bind disp_xmtr_regs disp_xmtr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_byte_vld(wr_byte_vld),
  .rd_strobe(rd_strobe), .finish(finish), .ptr(ptr), .rd_data(rd_data),
  .passthru(passthru), .skip_finish(skip_finish)
);

// File: tb/disp_xmtr_regs_bench.sv
module disp_xmtr_regs_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, rd_start = 0, wr_byte_vld = 0, rd_strobe = 0, finish = 0;
  logic [7:0] wr_byte = 0;
  logic [7:0] rd_data;
  logic passthru, skip_finish;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_xmtr_regs u_disp_xmtr_regs (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
    .wr_byte_vld(wr_byte_vld), .wr_byte(wr_byte), .rd_strobe(rd_strobe),
    .finish(finish), .rd_data(rd_data), .passthru(passthru),
    .skip_finish(skip_finish)
  );

  function automatic logic [7:0] expect_rd(input logic [7:0] a, input logic rq);
    if (a == 8'h1A) return rq ? 8'h06 : 8'h00;
    if (a == 8'h1B) return 8'hB0;
    if (a == 8'h3D) return 8'h04;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse_wstart();
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0;
  endtask

  task automatic pulse_rstart();
    @(negedge clk) rd_start = 1;
    @(negedge clk) rd_start = 0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk) begin wr_byte_vld = 1; wr_byte = b; end
    @(negedge clk) wr_byte_vld = 0;
  endtask

  task automatic get(output logic [7:0] d);
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    d = rd_data;
  endtask

  task automatic pulse_finish();
    @(negedge clk) finish = 1;
    @(negedge clk) finish = 0;
  endtask

  task automatic seek(input logic [7:0] a);
    pulse_wstart();
    put(a);
    pulse_rstart();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 passthru", {7'd0, passthru}, 8'h00);
    check("R1 skip", {7'd0, skip_finish}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);

    // R1 R3 R6 R7 R8 R9: sweep every address from the reset pointer
    for (int a = 0; a < 256; a++) begin
      get(d);
      check($sformatf("R7/R8/R9 addr %02h", a), d, expect_rd(8'(a), 1'b0));
    end
    // R3 wrap: 0xFF -> 0x00 -> 0x01 ... reach 0x1B again
    for (int a = 0; a < 27; a++) get(d);
    get(d);
    check("R3 wrap to 1B", d, 8'hB0);

    // R11 hold between strobes
    repeat (4) @(negedge clk);
    check("R11 hold", d, rd_data);

    // R2 pointer byte is not data
    pulse_wstart();
    put(8'h1A);
    check("R2 no mode change", {7'd0, passthru}, 8'h00);
    get(d);
    check("R2 read 1A idle", d, 8'h00);
    get(d);
    check("R3 after read", d, 8'hB0);

    // R4 request only
    pulse_wstart();
    put(8'h1A);
    put(8'h04);
    check("R4 req only passthru", {7'd0, passthru}, 8'h00);
    check("R4 req only skip", {7'd0, skip_finish}, 8'h00);
    get(d);
    check("R3 write advances", d, 8'hB0);
    seek(8'h1A);
    get(d);
    check("R6 request granted", d, 8'h06);

    // R4 request and grant
    pulse_wstart();
    put(8'h1A);
    put(8'h06);
    check("R4 passthru", {7'd0, passthru}, 8'h01);
    check("R4 skip", {7'd0, skip_finish}, 8'h01);
    pulse_finish();
    check("R10 skip cleared", {7'd0, skip_finish}, 8'h00);
    check("R10 passthru kept", {7'd0, passthru}, 8'h01);
    pulse_finish();
    check("R10 stays clear", {7'd0, skip_finish}, 8'h00);

    // R9 writes elsewhere ignored
    pulse_wstart();
    put(8'h1B);
    for (int i = 0; i < 34; i++) put(8'hFF);
    check("R9 passthru kept", {7'd0, passthru}, 8'h01);
    check("R9 skip kept", {7'd0, skip_finish}, 8'h00);
    get(d);
    check("R9 next addr 3D", d, 8'h04);
    seek(8'h1B);
    get(d);
    check("R9 id unchanged", d, 8'hB0);

    // R5 release
    pulse_wstart();
    put(8'h1A);
    put(8'h02);
    check("R5 passthru cleared", {7'd0, passthru}, 8'h00);
    seek(8'h1A);
    get(d);
    check("R5 request cleared", d, 8'h00);

    // R3 write wrap
    pulse_wstart();
    put(8'hFF);
    put(8'h00);
    for (int i = 0; i < 26; i++) put(8'h00);
    put(8'h06);
    check("R3 write wrap hits 1A", {7'd0, passthru}, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule